// File: doc/BRIEF.md
# GPU Command Packet Framer

This block sits behind a command-word FIFO in a graphics pipeline and turns a stream of 32-bit words into whole command packets. The first word of each packet carries the opcode in its top byte. The opcode fixes the packet length, except for two polyline families whose length is found by scanning for an end-marker word. A packet is passed on only once every one of its words has arrived. It then waits on a valid/ready output with its opcode, word count and words, and the FIFO is stalled until the packet has been taken.

Alongside the framing, the block snoops state that later stages need. Environment commands are kept in eight shadow registers. Textured primitives refresh the texture-page field in shadow register 1. A 13-bit status field is built from two of the shadow registers.

Top module: `gpu_pkt_framer`

## Requirements
- R1: A synchronous reset clears any partial packet and drops `pkt_valid`. It loads shadow register i with the value {8'(0xE0+i), 24'h0}, so `status_low` reads 0.
- R2: Below opcode 0x80 the total packet length is as follows. Opcode 0x02 is 3 words, and any other opcode under 0x20 is 1 word. For 0x20–0x3F, with n = 4 when bit 3 is set and 3 otherwise, the length is 1 + n·(1 + bit2) + (bit4 ? n−1 : 0). For 0x40–0x47 it is 3 words, and for 0x50–0x57 it is 4 words. For 0x60–0x7F it is 2 + bit2 + (bits 4:3 == 0 ? 1 : 0).
- R3: Opcodes 0x80–0x9F give 4-word packets, 0xA0–0xDF give 3-word packets and 0xE0–0xFF give 1-word packets.
- R4: A word with opcode 0xE0–0xE7 is stored whole into shadow register (opcode & 7). Opcodes 0xE8–0xFF leave every shadow register unchanged.
- R5: A flat polyline (0x48–0x4F) ends at the first word at index 3 or later that matches the end marker ((word & 0xF000F000) == 0x50005000). That marker word is the last word of the packet. A marker at index 1 or 2 is ignored.
- R6: A shaded polyline (0x58–0x5F) ends only at an end-marker word at an even index of 4 or more. The marker is the last word of the packet, and a marker at an odd index is ignored.
- R7: Textured primitives (0x24–0x27, 0x2C–0x2F, 0x34–0x37, 0x3C–0x3F) copy bits 8:0 of one of their words into shadow register 1 bits 8:0. The word used is index 4, or index 5 when opcode bit 4 is set. The other bits of shadow register 1 are kept.
- R8: `status_low[10:0]` equals shadow register 1 bits 10:0, and `status_low[12:11]` equals shadow register 6 bits 1:0.
- R9: A packet is not presented until its last word has been accepted. While a packet is presented, `in_ready` is low and no word is taken.
- R10: While `pkt_valid` is high and `pkt_ready` is low, the opcode, length and words stay unchanged. A packet is taken exactly once.
- R11: A polyline that reaches MAX_WORDS words without an end marker is closed at MAX_WORDS words, and the next word starts a new packet.
- R12: Word k of a packet appears on `pkt_words[32k+31:32k]`, with word 0 as the opcode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word available from FIFO |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| pkt_valid | output | 1 | A complete packet is presented |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_opcode | output | 8 | Opcode of the presented packet |
| pkt_len | output | $clog2(MAX_WORDS+1) | Word count of the presented packet |
| pkt_words | output | 32·MAX_WORDS | Packet words, word k at bits 32k+31:32k |
| env_regs | output | 256 | Shadow registers, register i at bits 32i+31:32i |
| status_low | output | 13 | Status bits built from shadow registers 1 and 6 |

## Verification
The packet appears on the output after the clock edge that accepts its last word, and the shadow registers and status bits change on the edge that accepts the word that writes them. The bench therefore drives each word before a rising edge and reads every result at the falling edge that follows. It looks for absence only after waiting several whole cycles. Once a packet is taken, `in_ready` returns one cycle later, and the stall test counts on that one-cycle gap to show that a word held during the stall is taken exactly once.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int WORD_W = 32;
  localparam int ENV_N  = 8;

  typedef enum logic [1:0] {
    LEN_FIXED       = 2'd0,
    LEN_POLY_FLAT   = 2'd1,
    LEN_POLY_SHADED = 2'd2
  } len_kind_e;

  // total words of a fixed-length packet
  function automatic logic [3:0] fixed_total(input logic [7:0] op);
    int n;
    int t;
    n = op[3] ? 4 : 3;
    case (op[7:5])
      3'b000:  t = (op == 8'h02) ? 3 : 1;
      3'b001:  t = 1 + n * (1 + int'(op[2])) + (op[4] ? n - 1 : 0);
      3'b010:  t = op[4] ? 4 : 3;
      3'b011:  t = 2 + int'(op[2]) + ((op[4:3] == 2'b00) ? 1 : 0);
      3'b100:  t = 4;
      3'b101,
      3'b110:  t = 3;
      default: t = 1;
    endcase
    return 4'(t);
  endfunction

  function automatic logic is_end_marker(input logic [WORD_W-1:0] w);
    return (w & 32'hF000_F000) == 32'h5000_5000;
  endfunction

endpackage

// File: rtl/pf_len_decode.sv
module pf_len_decode
  import pf_pkg::*;
(
  input  logic [7:0] op,
  output len_kind_e  kind,
  output logic [3:0] fixed_len,
  output logic       tex_hit,
  output logic [2:0] tex_idx,
  output logic       env_hit
);

  always_comb begin
    kind = LEN_FIXED;
    if (op[7:4] == 4'h4 && op[3]) kind = LEN_POLY_FLAT;
    if (op[7:4] == 4'h5 && op[3]) kind = LEN_POLY_SHADED;
  end

  assign fixed_len = fixed_total(op);
  assign tex_hit   = (op[7:5] == 3'b001) && op[2];
  assign tex_idx   = op[4] ? 3'd5 : 3'd4;
  assign env_hit   = (op[7:3] == 5'b11100);

endmodule

// File: rtl/pf_env_shadow.sv
module pf_env_shadow
  import pf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [2:0]              wr_sel,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic                    tp_en,
  input  logic [8:0]              tp_data,
  output logic [ENV_N*WORD_W-1:0] env_flat,
  output logic [12:0]             status_low
);

  logic [WORD_W-1:0] env [ENV_N];

  for (genvar i = 0; i < ENV_N; i++) begin : g_env
    always_ff @(posedge clk) begin
      if (rst) begin
        env[i] <= {8'(224 + i), 24'h0};
      end else if (wr_en && wr_sel == 3'(i)) begin
        env[i] <= wr_data;
      end else if (i == 1 && tp_en) begin
        env[i][8:0] <= tp_data;
      end
    end
    assign env_flat[i*WORD_W +: WORD_W] = env[i];
  end

  assign status_low = {env[6][1:0], env[1][10:0]};

endmodule

// File: rtl/pf_collect.sv
module pf_collect
  import pf_pkg::*;
#(
  parameter  int MAX_WORDS = 16,
  localparam int IDX_W     = $clog2(MAX_WORDS),
  localparam int LEN_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [WORD_W-1:0]           in_data,
  output logic                        in_ready,
  input  logic                        pkt_ready,
  input  len_kind_e                   kind,
  input  logic [3:0]                  fixed_len,
  output logic [7:0]                  cur_op,
  output logic [IDX_W-1:0]            cur_idx,
  output logic                        accept,
  output logic                        pkt_valid,
  output logic [7:0]                  pkt_opcode,
  output logic [LEN_W-1:0]            pkt_len,
  output logic [MAX_WORDS*WORD_W-1:0] pkt_words
);

  logic [IDX_W-1:0]  cnt;
  logic [7:0]        op_q;
  logic [WORD_W-1:0] mem [MAX_WORDS];
  logic              hit;
  logic              done;
  logic              marker;

  assign in_ready = !pkt_valid;
  assign accept   = in_valid && in_ready;
  assign cur_idx  = cnt;
  assign cur_op   = (cnt == '0) ? in_data[31:24] : op_q;
  assign marker   = is_end_marker(in_data);

  always_comb begin
    case (kind)
      LEN_POLY_FLAT:   hit = marker && (cnt >= IDX_W'(3));
      LEN_POLY_SHADED: hit = marker && (cnt >= IDX_W'(4)) && !cnt[0];
      default:         hit = (LEN_W'(cnt) + LEN_W'(1)) == LEN_W'(fixed_len);
    endcase
    done = hit || (cnt == IDX_W'(MAX_WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      op_q       <= '0;
      pkt_valid  <= 1'b0;
      pkt_opcode <= '0;
      pkt_len    <= '0;
    end else begin
      if (pkt_valid && pkt_ready) pkt_valid <= 1'b0;
      if (accept) begin
        if (cnt == '0) op_q <= in_data[31:24];
        if (done) begin
          pkt_valid  <= 1'b1;
          pkt_opcode <= cur_op;
          pkt_len    <= LEN_W'(cnt) + LEN_W'(1);
          cnt        <= '0;
        end else begin
          cnt <= cnt + IDX_W'(1);
        end
      end
    end
  end

  // word store, no reset so it maps onto RAM-style storage
  always_ff @(posedge clk) begin
    if (accept) mem[cnt] <= in_data;
  end

  for (genvar k = 0; k < MAX_WORDS; k++) begin : g_out
    assign pkt_words[k*WORD_W +: WORD_W] = mem[k];
  end

endmodule

// File: rtl/gpu_pkt_framer.sv
module gpu_pkt_framer
  import pf_pkg::*;
#(
  parameter  int MAX_WORDS = 16,
  localparam int IDX_W     = $clog2(MAX_WORDS),
  localparam int LEN_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [31:0]                 in_data,
  output logic                        in_ready,
  output logic                        pkt_valid,
  input  logic                        pkt_ready,
  output logic [7:0]                  pkt_opcode,
  output logic [LEN_W-1:0]            pkt_len,
  output logic [MAX_WORDS*32-1:0]     pkt_words,
  output logic [255:0]                env_regs,
  output logic [12:0]                 status_low
);

  len_kind_e        kind;
  logic [3:0]       fixed_len;
  logic             tex_hit;
  logic [2:0]       tex_idx;
  logic             env_hit;
  logic [7:0]       cur_op;
  logic [IDX_W-1:0] cur_idx;
  logic             accept;
  logic             env_wr;
  logic             tp_wr;

  pf_len_decode u_dec (
    .op        (cur_op),
    .kind      (kind),
    .fixed_len (fixed_len),
    .tex_hit   (tex_hit),
    .tex_idx   (tex_idx),
    .env_hit   (env_hit)
  );

  pf_collect #(.MAX_WORDS(MAX_WORDS)) u_col (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .pkt_ready  (pkt_ready),
    .kind       (kind),
    .fixed_len  (fixed_len),
    .cur_op     (cur_op),
    .cur_idx    (cur_idx),
    .accept     (accept),
    .pkt_valid  (pkt_valid),
    .pkt_opcode (pkt_opcode),
    .pkt_len    (pkt_len),
    .pkt_words  (pkt_words)
  );

  assign env_wr = accept && env_hit && (cur_idx == '0);
  assign tp_wr  = accept && tex_hit && (cur_idx == IDX_W'(tex_idx));

  pf_env_shadow u_env (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (env_wr),
    .wr_sel     (cur_op[2:0]),
    .wr_data    (in_data),
    .tp_en      (tp_wr),
    .tp_data    (in_data[8:0]),
    .env_flat   (env_regs),
    .status_low (status_low)
  );

endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter  int MAX_WORDS = 16,
  localparam int LEN_W     = $clog2(MAX_WORDS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic [7:0]       pkt_opcode,
  input logic [LEN_W-1:0] pkt_len
);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_opcode) && $stable(pkt_len));

  // R3
  single_word_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_opcode[7:5] == 3'b111 |-> pkt_len == LEN_W'(1));

  // R3
  copy_len_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_opcode[7:5] == 3'b100 |-> pkt_len == LEN_W'(4));

  // R3
  xfer_len_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && (pkt_opcode[7:5] == 3'b101 || pkt_opcode[7:5] == 3'b110) |-> pkt_len == LEN_W'(3));

  // R11
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> pkt_len != '0 && pkt_len <= LEN_W'(MAX_WORDS));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !pkt_valid);

endmodule

bind gpu_pkt_framer pf_checker #(.MAX_WORDS(MAX_WORDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pkt_valid  (pkt_valid),
  .pkt_ready  (pkt_ready),
  .pkt_opcode (pkt_opcode),
  .pkt_len    (pkt_len)
);

// File: tb/tb_gpu_pkt_framer.sv
module tb_gpu_pkt_framer;

  localparam int MAXW  = 16;
  localparam int LEN_W = $clog2(MAXW + 1);
  localparam logic [31:0] MARK = 32'h5000_5000;

  logic               clk = 0;
  logic               rst = 1;
  logic               in_valid = 0;
  logic [31:0]        in_data = 0;
  logic               in_ready;
  logic               pkt_valid;
  logic               pkt_ready = 0;
  logic [7:0]         pkt_opcode;
  logic [LEN_W-1:0]   pkt_len;
  logic [MAXW*32-1:0] pkt_words;
  logic [255:0]       env_regs;
  logic [12:0]        status_low;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpu_pkt_framer #(.MAX_WORDS(MAXW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_opcode(pkt_opcode),
    .pkt_len(pkt_len), .pkt_words(pkt_words), .env_regs(env_regs), .status_low(status_low)
  );

  // first word, expected total length
  localparam logic [39:0] VEC [20] = '{
    {32'h0000_0000, 8'd1},  {32'h0200_0000, 8'd3},  {32'h2000_0000, 8'd4},
    {32'h2400_0000, 8'd7},  {32'h2800_0000, 8'd5},  {32'h2C00_0000, 8'd9},
    {32'h3000_0000, 8'd6},  {32'h3400_0000, 8'd9},  {32'h3800_0000, 8'd8},
    {32'h3C00_0000, 8'd12}, {32'h4000_0000, 8'd3},  {32'h5000_0000, 8'd4},
    {32'h6000_0000, 8'd3},  {32'h6400_0000, 8'd4},  {32'h6800_0000, 8'd2},
    {32'h6C00_0000, 8'd3},  {32'h8000_0000, 8'd4},  {32'hA000_0000, 8'd3},
    {32'hC000_0000, 8'd3},  {32'hFF00_0000, 8'd1}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic take(input string req, input logic [7:0] op, input int len);
    int n;
    n = 0;
    @(negedge clk);
    while (!pkt_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(req, "pkt_valid", 64'(pkt_valid), 64'd1);
    chk(req, "opcode", 64'(pkt_opcode), 64'(op));
    chk(req, "length", 64'(pkt_len), 64'(len));
    pkt_ready = 1;
    @(posedge clk);
    #1 pkt_ready = 0;
  endtask

  function automatic logic [31:0] env(input int i);
    return env_regs[i*32 +: 32];
  endfunction

  function automatic logic [31:0] word(input int k);
    return pkt_words[k*32 +: 32];
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [255:0] snap;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pkt_valid", 64'(pkt_valid), 64'd0);
    chk("R1", "in_ready", 64'(in_ready), 64'd1);
    chk("R1", "env0", 64'(env(0)), 64'hE000_0000);
    chk("R1", "env7", 64'(env(7)), 64'hE700_0000);
    chk("R8", "status after reset", 64'(status_low), 64'd0);

    // R2 / R3 table walk
    for (int i = 0; i < 20; i++) begin
      logic [31:0] first;
      int len;
      first = VEC[i][39:8];
      len   = int'(VEC[i][7:0]);
      push(first);
      for (int k = 1; k < len; k++) push(32'h0000_0000);
      take((first[31:24] < 8'h80) ? "R2" : "R3", first[31:24], len);
    end

    // R4 environment write, R8 status
    push(32'hE100_03FF);
    take("R4", 8'hE1, 1);
    chk("R4", "env1", 64'(env(1)), 64'hE100_03FF);
    chk("R8", "status low field", 64'(status_low), 64'h03FF);
    push(32'hE600_0003);
    take("R4", 8'hE6, 1);
    chk("R8", "status with env6", 64'(status_low), 64'h1BFF);
    snap = env_regs;
    push(32'hE8AB_CDEF);
    take("R4", 8'hE8, 1);
    chk("R4", "E8 leaves shadow regs", 64'(env_regs == snap), 64'd1);

    // R7 texture page, word 4 for flat textured
    push(32'h2C00_0000);
    for (int k = 1; k < 9; k++) push((k == 4) ? 32'h0000_01AB : 32'h0);
    take("R7", 8'h2C, 9);
    chk("R7", "env1 from word4", 64'(env(1)), 64'hE100_03AB);
    chk("R8", "status after texpage", 64'(status_low), 64'h1BAB);
    // R7 shaded textured uses word 5
    push(32'h3C00_0000);
    for (int k = 1; k < 12; k++)
      push((k == 4) ? 32'h0000_01FF : (k == 5) ? 32'h0000_0055 : 32'h0);
    take("R7", 8'h3C, 12);
    chk("R7", "env1 from word5", 64'(env(1)), 64'hE100_0255);

    // R5 flat polyline, marker at index 2 ignored
    push(32'h4800_0000);
    push(32'h0000_0001);
    push(MARK);
    push(32'h0000_0002);
    push(MARK | 32'h0555_0555);
    @(negedge clk);
    chk("R12", "word0", 64'(word(0)), 64'h4800_0000);
    chk("R12", "word3", 64'(word(3)), 64'h0000_0002);
    chk("R5", "last word is marker", 64'(word(4)), 64'h5555_5555);
    take("R5", 8'h48, 5);

    // R6 shaded polyline, odd-index marker ignored
    push(32'h5800_0000);
    for (int k = 1; k < 5; k++) push(32'h0);
    push(MARK);
    push(MARK);
    take("R6", 8'h58, 7);

    // R11 polyline forced close
    push(32'h4A00_0000);
    for (int k = 1; k < MAXW; k++) push(32'h0000_0000);
    take("R11", 8'h4A, MAXW);
    push(32'hE900_0000);
    take("R11", 8'hE9, 1);

    // R9 incomplete packet held back
    push(32'h8000_0000);
    push(32'h0000_0011);
    push(32'h0000_0022);
    repeat (4) @(negedge clk);
    chk("R9", "no early packet", 64'(pkt_valid), 64'd0);
    chk("R9", "ready while collecting", 64'(in_ready), 64'd1);
    push(32'h0000_0033);
    @(negedge clk);
    chk("R12", "word1", 64'(word(1)), 64'h0000_0011);
    chk("R12", "word3", 64'(word(3)), 64'h0000_0033);
    take("R9", 8'h80, 4);

    // R10 hold under stall, stalled word taken exactly once
    push(32'hE201_2345);
    repeat (3) @(negedge clk);
    chk("R10", "held valid", 64'(pkt_valid), 64'd1);
    chk("R10", "held opcode", 64'(pkt_opcode), 64'hE2);
    chk("R9", "in_ready low when pending", 64'(in_ready), 64'd0);
    in_valid = 1;
    in_data  = 32'hE30A_BCDE;
    repeat (2) @(negedge clk);
    chk("R9", "stalled word not taken", 64'(env(3)), 64'hE300_0000);
    pkt_ready = 1;
    @(negedge clk);
    pkt_ready = 0;
    @(posedge clk);
    #1 in_valid = 0;
    take("R10", 8'hE3, 1);
    chk("R10", "env3 written once", 64'(env(3)), 64'hE30A_BCDE);
    repeat (3) @(negedge clk);
    chk("R10", "no duplicate packet", 64'(pkt_valid), 64'd0);

    // R1 reset mid-packet
    push(32'h8000_0000);
    push(32'h0000_0001);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "env1 restored", 64'(env(1)), 64'hE100_0000);
    chk("R1", "no packet after reset", 64'(pkt_valid), 64'd0);
    push(32'hEA00_0000);
    take("R1", 8'hEA, 1);

    finish_run();
  end

endmodule